// File: doc/BRIEF.md
# FM Synthesis Operator Datapath

This block produces one sample of a frequency-modulated sine operator each time its sample strobe is raised. A 20-bit phase accumulator advances by a programmable increment. Its top ten bits, plus a signed modulation input, select a point on the waveform. The amplitude is formed entirely in the log domain. A half-wave log-sine attenuation table is summed with an envelope attenuation, and the total is turned back into a linear magnitude through an exponent table and a binary shift. The phase sign bit then mirrors the result into the negative half of the wave.

The registered result is available one cycle after the strobe. The previous result is kept alongside it, so that a surrounding channel can form a self-feedback modulation term. Two independent enables route the sample to a left and a right output. The envelope rate logic, the routing of operators into algorithms and the conversion to analogue sit outside this block. They drive `envAtt` and `modIn` and consume the outputs.

Top module: `fmOperator`

## Requirements
- R1: After reset, `opOut`, `histOld`, `leftOut` and `rightOut` are zero, `outValid` is low, and the phase accumulator and the increment register are zero.
- R2: On each strobe, the operator phase is bits [19:10] of the accumulator as it stands before the step. The accumulator then grows by the increment register, modulo 2^20.
- R3: The modulated phase is (phase + `modIn`) mod 1024. Bit 9 of it is the sign. Bits [8:0] select table entry i = floor(256 * -log2(sin((2i+1)*pi/1024))).
- R4: The total attenuation T is the table entry plus 4*`envAtt`. With m = T[7:0] and u = T[11:8], the base value is L = floor(2048 * 2^(-(m+1)/256)). The magnitude is L<<(2-u) for u<2, and L>>(u-2) otherwise.
- R5: A total attenuation of 4096 or more gives a zero output. An all-ones `envAtt` always gives silence.
- R6: When bit 9 of the modulated phase is set, the magnitude is negated. `opOut` always lies in -0x1FFF..+0x1FFF.
- R7: `opOut` and `outValid` are registered. The sample for a strobe appears after the next rising edge, with `outValid` high for exactly that cycle. `opOut` holds when there is no strobe.
- R8: With each new sample, `histOld` takes the value `opOut` had just before the update.
- R9: `keyOn` clears the accumulator. A strobe in the same cycle uses phase zero and leaves the accumulator equal to the increment.
- R10: `incWe` loads `incData` into the increment register. A strobe in the same cycle still steps by the old increment.
- R11: `leftOut` equals `opOut` when `enLeft` is 1 and is zero otherwise. `rightOut` behaves the same way under `enRight`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample strobe; computes one operator sample |
| keyOn | input | 1 | Clears the phase accumulator |
| incWe | input | 1 | Write enable for the phase increment |
| incData | input | 20 | New phase increment |
| modIn | input | 10 | Two's-complement phase modulation |
| envAtt | input | 10 | Envelope attenuation, larger is quieter |
| enLeft | input | 1 | Routes the sample to the left output |
| enRight | input | 1 | Routes the sample to the right output |
| outValid | output | 1 | High in the cycle after a strobe |
| opOut | output | 16 | Signed operator sample, scale 2^-13 |
| histOld | output | 16 | Sample preceding `opOut`, for feedback |
| leftOut | output | 16 | Gated left sample |
| rightOut | output | 16 | Gated right sample |

## Verification
The bound checker watches several properties on every cycle:
- the one-cycle strobe-to-valid latency;
- that the output holds between strobes;
- the shift of the output into the history register;
- the output range bound;
- the silence forced by a full envelope attenuation.

The exact amplitude for a given phase, modulation and envelope, and the accumulator stepping, can only be shown by the bench's scenarios against its real-valued model. The same applies to the ordering of key-on and increment writes against a strobe, and to the left/right gating.

// File: rtl/fmOpPkg.sv
`timescale 1ns/1ps
package fmOpPkg;
  localparam int PHASE_W    = 20;
  localparam int PH_BITS    = 10;
  localparam int IDX_BITS   = PH_BITS - 1;
  localparam int SINE_DEPTH = 1 << IDX_BITS;
  localparam int ATT_W      = 12;
  localparam int MANT_BITS  = 8;
  localparam int EXP_DEPTH  = 1 << MANT_BITS;
  localparam int LIN_W      = 11;
  localparam int ZERO_POINT = 2;
  localparam int MAG_W      = LIN_W + ZERO_POINT;
  localparam int ENV_W      = 10;
  localparam int ENV_SHIFT  = 2;
  localparam int OUT_W      = 16;
  localparam int TOT_W      = ATT_W + 1;
  localparam real PI_R      = 3.14159265358979;

  typedef struct packed {
    logic               sample;
    logic [PH_BITS-1:0] phase;
  } opStrobe_t;

  function automatic logic [ATT_W-1:0] logSineAt(int i);
    real ang;
    real lg;
    ang = (real'(2 * i + 1) / real'(2 * SINE_DEPTH)) * PI_R;
    lg  = -$ln($sin(ang)) / $ln(2.0);
    return ATT_W'($rtoi(lg * real'(1 << MANT_BITS)));
  endfunction

  function automatic logic [LIN_W-1:0] expAt(int m);
    real v;
    v = (2.0 ** (-real'(m + 1) / real'(EXP_DEPTH))) * real'(1 << LIN_W);
    return LIN_W'($rtoi(v));
  endfunction
endpackage

// File: rtl/fmOpCtrl.sv
`timescale 1ns/1ps
module fmOpCtrl
  import fmOpPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic               keyOn,
  input  logic               incWe,
  input  logic [PHASE_W-1:0] incData,
  output opStrobe_t          strobe
);
  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] incReg;
  logic [PHASE_W-1:0] accBase;

  // key-on restarts the wave before the current step is taken
  assign accBase = keyOn ? '0 : acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      incReg <= '0;
    end else begin
      if (incWe) incReg <= incData;
      acc <= sampleEn ? accBase + incReg : accBase;
    end
  end

  always_comb begin
    strobe.sample = sampleEn;
    strobe.phase  = accBase[PHASE_W-1 -: PH_BITS];
  end
endmodule

// File: rtl/fmOpDatapath.sv
`timescale 1ns/1ps
module fmOpDatapath
  import fmOpPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  opStrobe_t               strobe,
  input  logic [PH_BITS-1:0]      modIn,
  input  logic [ENV_W-1:0]        envAtt,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] opOut,
  output logic signed [OUT_W-1:0] histOld
);
  logic [ATT_W-1:0] sineRom [SINE_DEPTH];
  logic [LIN_W-1:0] expRom  [EXP_DEPTH];

  for (genvar gi = 0; gi < SINE_DEPTH; gi++) begin : g_sine
    localparam logic [ATT_W-1:0] ENTRY = logSineAt(gi);
    assign sineRom[gi] = ENTRY;
  end

  for (genvar gj = 0; gj < EXP_DEPTH; gj++) begin : g_exp
    localparam logic [LIN_W-1:0] ENTRY = expAt(gj);
    assign expRom[gj] = ENTRY;
  end

  logic [PH_BITS-1:0]          modPhase;
  logic [TOT_W-1:0]            totalAtt;
  logic [LIN_W-1:0]            linBase;
  logic [ATT_W-MANT_BITS-1:0]  octave;
  logic [MAG_W-1:0]            mag;
  logic signed [OUT_W-1:0]     magS;
  logic signed [OUT_W-1:0]     nextOut;

  assign modPhase = strobe.phase + modIn;
  assign totalAtt = TOT_W'(sineRom[modPhase[IDX_BITS-1:0]])
                  + (TOT_W'(envAtt) << ENV_SHIFT);
  assign linBase  = expRom[totalAtt[MANT_BITS-1:0]];
  assign octave   = totalAtt[ATT_W-1:MANT_BITS];

  always_comb begin
    if (totalAtt[ATT_W])
      mag = '0;
    else if (int'(octave) < ZERO_POINT)
      mag = MAG_W'(linBase) << (ZERO_POINT - int'(octave));
    else
      mag = MAG_W'(linBase) >> (int'(octave) - ZERO_POINT);
  end

  assign magS    = signed'(OUT_W'(mag));
  assign nextOut = modPhase[PH_BITS-1] ? -magS : magS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      opOut    <= '0;
      histOld  <= '0;
    end else begin
      outValid <= strobe.sample;
      if (strobe.sample) begin
        histOld <= opOut;
        opOut   <= nextOut;
      end
    end
  end
endmodule

// File: rtl/fmOperator.sv
`timescale 1ns/1ps
module fmOperator
  import fmOpPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleEn,
  input  logic                    keyOn,
  input  logic                    incWe,
  input  logic [PHASE_W-1:0]      incData,
  input  logic [PH_BITS-1:0]      modIn,
  input  logic [ENV_W-1:0]        envAtt,
  input  logic                    enLeft,
  input  logic                    enRight,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] opOut,
  output logic signed [OUT_W-1:0] histOld,
  output logic signed [OUT_W-1:0] leftOut,
  output logic signed [OUT_W-1:0] rightOut
);
  opStrobe_t strobe;

  fmOpCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .keyOn    (keyOn),
    .incWe    (incWe),
    .incData  (incData),
    .strobe   (strobe)
  );

  fmOpDatapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .modIn    (modIn),
    .envAtt   (envAtt),
    .outValid (outValid),
    .opOut    (opOut),
    .histOld  (histOld)
  );

  assign leftOut  = enLeft  ? opOut : '0;
  assign rightOut = enRight ? opOut : '0;
endmodule

// File: rtl/fmOperatorChk.sv
`timescale 1ns/1ps
module fmOperatorChk
  import fmOpPkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    sampleEn,
  input logic [ENV_W-1:0]        envAtt,
  input logic                    outValid,
  input logic signed [OUT_W-1:0] opOut,
  input logic signed [OUT_W-1:0] histOld
);
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> outValid); // R7
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> !outValid); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(opOut)); // R7
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> (histOld == $past(opOut))); // R8
  AST_ENV_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && (envAtt == '1)) |=> (opOut == '0)); // R5
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (opOut <= 16'sh1FFF) && (opOut >= -16'sh1FFF)); // R6
endmodule

bind fmOperator fmOperatorChk chk_i (.*);

// File: tb/fmOperator_tb_top.sv
`timescale 1ns/1ps
module fmOperator_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0;
  logic keyOn = 1'b0;
  logic incWe = 1'b0;
  logic [19:0] incData = '0;
  logic [9:0] modIn = '0;
  logic [9:0] envAtt = '0;
  logic enLeft = 1'b0;
  logic enRight = 1'b0;
  logic outValid;
  logic signed [15:0] opOut, histOld, leftOut, rightOut;

  int checks = 0;
  int failures = 0;
  int mAcc = 0;
  int mInc = 0;
  localparam real PI_B = 3.14159265358979;

  always #2.5 clk = ~clk;

  fmOperator dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int refOp(input int ph, input int md, input int env);
    int mp, idx, att, tot, m, u, lin, mag;
    real ang;
    mp  = (ph + md) & 1023;
    idx = mp & 511;
    ang = (2.0 * real'(idx) + 1.0) / 1024.0 * PI_B;
    att = $rtoi(-$ln($sin(ang)) / $ln(2.0) * 256.0);
    tot = att + env * 4;
    if (tot >= 4096) mag = 0;
    else begin
      m = tot & 255;
      u = tot >> 8;
      lin = $rtoi((2.0 ** (-real'(m + 1) / 256.0)) * 2048.0);
      mag = (u < 2) ? (lin << (2 - u)) : (lin >> (u - 2));
    end
    return ((mp & 512) != 0) ? -mag : mag;
  endfunction

  // called at a falling edge; one strobe, checked after the following rising edge
  task automatic doSample(input int md, input int env, input bit kOn,
                          input bit wr, input int wrVal, input string req);
    int base, ph, expv, prev, diff;
    modIn = 10'(md); envAtt = 10'(env); keyOn = kOn;
    incWe = wr; incData = 20'(wrVal); sampleEn = 1'b1;
    base = kOn ? 0 : mAcc;
    ph   = (base >> 10) & 1023;
    expv = refOp(ph, md & 1023, env);
    mAcc = (base + mInc) & 20'hFFFFF;
    if (wr) mInc = wrVal & 20'hFFFFF;
    prev = int'(opOut);
    @(posedge clk); #1;
    diff = int'(opOut) - expv;
    chk(diff >= -1 && diff <= 1, req, int'(opOut), expv);
    chk(int'(histOld) == prev, "R8 history", int'(histOld), prev);
    chk(outValid == 1'b1, "R7 valid", int'(outValid), 1);
    @(negedge clk);
    sampleEn = 1'b0; keyOn = 1'b0; incWe = 1'b0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int held;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(opOut == 0 && histOld == 0, "R1 outputs", int'(opOut), 0);
    chk(outValid == 0, "R1 valid", int'(outValid), 0);
    chk(leftOut == 0 && rightOut == 0, "R1 gated", int'(leftOut), 0);
    @(negedge clk);
    // R1 accumulator and increment at zero: phase 0 twice
    doSample(0, 0, 0, 0, 0, "R1 phase zero");
    doSample(0, 0, 0, 0, 0, "R1 increment zero");

    // R10 increment write alone, then R2 stepping
    incWe = 1'b1; incData = 20'h0C400; mInc = 20'h0C400;
    @(negedge clk); incWe = 1'b0;
    for (int k = 0; k < 40; k++) doSample(0, 0, 0, 0, 0, "R2 phase step");
    // R10 write with strobe: old increment used for this step
    doSample(0, 0, 0, 1, 20'h00400, "R10 same-cycle write");
    doSample(0, 0, 0, 0, 0, "R10 new increment");

    // R4 peak and R6 mirror at phase 0
    doSample(10'h100, 0, 1, 0, 0, "R4 peak");
    chk(opOut == 16'sd8168, "R4 peak value", int'(opOut), 8168);
    doSample(10'h300, 0, 1, 0, 0, "R6 negative half");
    chk(opOut == -16'sd8168, "R6 mirrored value", int'(opOut), -8168);
    // R4 one octave down: envelope 64 adds 256
    doSample(10'h100, 64, 1, 0, 0, "R4 octave");
    chk(opOut == 16'sd4084, "R4 octave value", int'(opOut), 4084);

    // R5 saturation and full envelope
    doSample(10'h000, 1000, 1, 0, 0, "R5 saturate");
    chk(opOut == 0, "R5 saturate zero", int'(opOut), 0);
    doSample(10'h100, 1023, 0, 0, 0, "R5 full envelope");

    // R9 key-on alone, then strobe uses phase 0
    doSample(0, 0, 0, 1, 20'h1F000, "R9 setup");
    for (int k = 0; k < 5; k++) doSample(10'h155, 3, 0, 0, 0, "R9 advance");
    keyOn = 1'b1; mAcc = 0;
    @(negedge clk); keyOn = 1'b0;
    doSample(10'h100, 0, 0, 0, 0, "R9 restart");
    chk(opOut == 16'sd8168, "R9 restart value", int'(opOut), 8168);
    doSample(10'h100, 0, 1, 0, 0, "R9 same-cycle key-on");

    // R7 hold while idle
    held = int'(opOut);
    repeat (4) @(negedge clk);
    chk(int'(opOut) == held && outValid == 0, "R7 hold", int'(opOut), held);

    // R11 gating, all four combinations
    for (int c = 0; c < 4; c++) begin
      enLeft = c[0]; enRight = c[1];
      #1;
      chk(leftOut == (enLeft ? opOut : 16'sd0), "R11 left", int'(leftOut),
          enLeft ? int'(opOut) : 0);
      chk(rightOut == (enRight ? opOut : 16'sd0), "R11 right", int'(rightOut),
          enRight ? int'(opOut) : 0);
    end
    enLeft = 1'b0; enRight = 1'b0;

    // R3 R4 R6 constrained random sweep
    for (int k = 0; k < 400; k++) begin
      int env, r;
      r = int'($urandom_range(0, 9));
      env = (r < 6) ? int'($urandom_range(0, 200)) : int'($urandom_range(0, 1023));
      doSample(int'($urandom_range(0, 1023)), env, ($urandom_range(0, 49) == 0),
               ($urandom_range(0, 19) == 0), int'($urandom_range(0, 20'hFFFFF)),
               "R3 random sample");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule